// File: doc/BRIEF.md
# Processor Status Word with Arithmetic Condition Flags

This block keeps a 16-bit status word for a small processor core. Six condition flags (carry, parity, auxiliary carry, zero, sign, overflow) are worked out from the two operands and the selected operation. The operation may be add, add with carry, subtract, subtract with borrow, or one of three bitwise logical operations. Each runs at byte or word width. Three control flags (trap, interrupt enable, direction) change only through explicit set and clear commands or through a full-word load. Arithmetic and logical operations never touch them.

The execution stage presents its operands, operation code and width together with an update enable. The register takes the new flags on the next rising clock edge. A full-word load is used to restore a saved status word. It overrides every other request in the same cycle. Reserved positions always read as zero.

Top module: `psw_flag_unit`

## Requirements
- R1: Word layout: carry bit 0, parity bit 2, auxiliary carry bit 4, zero bit 6, sign bit 7, trap bit 8, interrupt enable bit 9, direction bit 10, overflow bit 11; bits 1, 3, 5 and 12 to 15 always read 0.
- R2: A synchronous active-low reset clears the whole word at the clock edge where it is sampled low.
- R3: Zero is set when the result is zero over the active width only (low 8 bits when `wide`=0, all 16 when `wide`=1); sign is result bit 7 for byte and bit 15 for word operations.
- R4: Parity is set when the low 8 result bits hold an even number of ones, at either width.
- R5: Carry is set on a carry out of (add) or a borrow into (subtract) the top bit of the active width; op code 1 adds and op code 3 subtracts the current carry flag as carry-in or borrow-in, while codes 0 and 2 ignore it.
- R6: Auxiliary carry is set on a carry out of bit 3 in add operations or a borrow into bit 3 in subtract operations.
- R7: Overflow is set when the signed result at the active width does not fit, that is when the operands' signs imply a result sign different from the actual one.
- R8: Logical codes 4 (AND), 5 (OR) and 6 (XOR) clear carry and overflow, leave auxiliary carry unchanged, and set zero, sign and parity from the result.
- R9: Control flags are never changed by operations; `ctl_set`/`ctl_clr` bit 0 is trap, bit 1 interrupt enable, bit 2 direction; a set and a clear of the same flag in one cycle leaves it set.
- R10: When `ld_en` is high, the nine defined bits take `ld_word` and all other requests that cycle are ignored; reserved bits of `ld_word` are dropped.
- R11: Condition flags change only when `upd_en` is high and the op code is not 7; code 7 or a low enable leaves all six unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand (subtrahend for subtract) |
| op | input | 3 | 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 OR, 6 XOR, 7 none |
| wide | input | 1 | 1 = word (16-bit), 0 = byte (low 8 bits) |
| upd_en | input | 1 | Condition flag update enable |
| ctl_set | input | 3 | Control flag set commands |
| ctl_clr | input | 3 | Control flag clear commands |
| ld_en | input | 1 | Full-word load enable |
| ld_word | input | 16 | Word to load |
| flags | output | 16 | Status word |

## Verification
The bench targets the byte/word boundary. It uses byte operations with non-zero upper operand bits, where a design that ignores the width would clear zero or take sign from bit 15. Signed overflow at 0x7F+1 and 0x8000+0x8000 is covered, as is borrow through zero, where a design that swaps carry and borrow polarity would report the wrong carry and auxiliary carry. It also covers carry-chained add and subtract, logical operations after a set auxiliary carry, and loads that coincide with set, clear and update requests. A wrong priority there would leak a command into the loaded word.

// File: rtl/psw_pkg.sv
// Package: shared types, word layout and pack/unpack helpers for the status word.
// Assumes a fixed 16-bit word; flag positions are part of the block's behaviour.
package psw_pkg;

    localparam int WORD_W   = 16;
    localparam int CF_POS   = 0;
    localparam int PF_POS   = 2;
    localparam int AF_POS   = 4;
    localparam int ZF_POS   = 6;
    localparam int SF_POS   = 7;
    localparam int TF_POS   = 8;
    localparam int IF_POS   = 9;
    localparam int DF_POS   = 10;
    localparam int OF_POS   = 11;
    localparam int CTL_N    = 3;
    localparam int PAR_W    = 8;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADC  = 3'd1,
        OP_SUB  = 3'd2,
        OP_SBB  = 3'd3,
        OP_AND  = 3'd4,
        OP_OR   = 3'd5,
        OP_XOR  = 3'd6,
        OP_NONE = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic of_f;
        logic sf_f;
        logic zf_f;
        logic af_f;
        logic pf_f;
        logic cf_f;
    } cond_t;

    // Assemble the status word; reserved positions stay zero.
    function automatic logic [WORD_W-1:0] pack_word(cond_t c, logic [CTL_N-1:0] k);
        logic [WORD_W-1:0] w;
        w         = '0;
        w[CF_POS] = c.cf_f;
        w[PF_POS] = c.pf_f;
        w[AF_POS] = c.af_f;
        w[ZF_POS] = c.zf_f;
        w[SF_POS] = c.sf_f;
        w[OF_POS] = c.of_f;
        w[TF_POS] = k[0];
        w[IF_POS] = k[1];
        w[DF_POS] = k[2];
        return w;
    endfunction

    // Extract the condition flags from a word.
    function automatic cond_t cond_of(logic [WORD_W-1:0] w);
        cond_t c;
        c.cf_f = w[CF_POS];
        c.pf_f = w[PF_POS];
        c.af_f = w[AF_POS];
        c.zf_f = w[ZF_POS];
        c.sf_f = w[SF_POS];
        c.of_f = w[OF_POS];
        return c;
    endfunction

    // Extract the control flags (bit0 trap, bit1 interrupt, bit2 direction).
    function automatic logic [CTL_N-1:0] ctl_of(logic [WORD_W-1:0] w);
        return {w[DF_POS], w[IF_POS], w[TF_POS]};
    endfunction

endpackage

// File: rtl/psw_cond_eval.sv
// Module: psw_cond_eval
// Combinational derivation of the six condition flags from operands, op code
// and width. Subtraction runs as a + ~b + ~borrow; carry and auxiliary
// carry are inverted afterwards to report borrows. Assumes DATA_W is even
// and at least 8; byte mode uses the low DATA_W/2 bits.
module psw_cond_eval
    import psw_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [2:0]        op,
    input  logic              wide,
    input  logic              cur_cf,
    input  logic              cur_af,
    output cond_t             cond_nxt
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] wmask;
    logic [DATA_W-1:0] a_m;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W-1:0] lres;
    logic [DATA_W-1:0] res;
    logic [DATA_W:0]   sum;
    logic              is_sub;
    logic              is_logic;
    logic              cin;
    logic              carry_out;
    logic              c4;
    logic              a_s;
    logic              b_s;
    logic              r_s;

    // Decode the op code and build width-masked adder inputs.
    always_comb begin
        wmask    = wide ? {DATA_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
        is_sub   = (op == OP_SUB) || (op == OP_SBB);
        is_logic = op[2];
        cin      = ((op == OP_ADC) || (op == OP_SBB)) ? cur_cf : 1'b0;
        if (is_sub) begin
            cin = ~cin;
        end
        a_m   = opa & wmask;
        b_eff = (is_sub ? ~opb : opb) & wmask;
    end

    // Shared adder for all four arithmetic operations.
    always_comb begin
        sum = {1'b0, a_m} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};
    end

    // Bitwise result for the logical group.
    always_comb begin
        case (op)
            OP_OR:   lres = opa | opb;
            OP_XOR:  lres = opa ^ opb;
            default: lres = opa & opb;
        endcase
    end

    // Pick the result and the sign bits at the active width.
    always_comb begin
        res       = (is_logic ? lres : sum[DATA_W-1:0]) & wmask;
        carry_out = wide ? sum[DATA_W] : sum[HALF_W];
        a_s       = wide ? a_m[DATA_W-1]   : a_m[HALF_W-1];
        b_s       = wide ? b_eff[DATA_W-1] : b_eff[HALF_W-1];
        r_s       = wide ? res[DATA_W-1]   : res[HALF_W-1];
        c4        = a_m[4] ^ b_eff[4] ^ sum[4];
    end

    // Form the condition flags.
    always_comb begin
        cond_nxt.zf_f = (res == '0);
        cond_nxt.sf_f = r_s;
        cond_nxt.pf_f = ~^res[PAR_W-1:0];
        if (is_logic) begin
            cond_nxt.cf_f = 1'b0;
            cond_nxt.of_f = 1'b0;
            cond_nxt.af_f = cur_af;
        end else begin
            cond_nxt.cf_f = is_sub ? ~carry_out : carry_out;
            cond_nxt.af_f = is_sub ? ~c4 : c4;
            cond_nxt.of_f = (a_s == b_s) && (r_s != a_s);
        end
    end

endmodule

// File: rtl/psw_state_reg.sv
// Module: psw_state_reg
// Storage for the condition and control flags with load/command/update
// priority: reset, then full load, then independent control commands and
// condition update. Assumes cond_nxt is valid whenever upd_en is high.
module psw_state_reg
    import psw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [WORD_W-1:0] ld_word,
    input  logic              upd_en,
    input  logic [2:0]        op,
    input  logic [CTL_N-1:0]  ctl_set,
    input  logic [CTL_N-1:0]  ctl_clr,
    input  cond_t             cond_nxt,
    output cond_t             cond_q,
    output logic [CTL_N-1:0]  ctl_q
);
    logic cond_we;

    // Condition write strobe: enabled and not the no-op code.
    always_comb begin
        cond_we = upd_en && (op != OP_NONE);
    end

    // Flag storage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_q <= '0;
            ctl_q  <= '0;
        end else if (ld_en) begin
            cond_q <= cond_of(ld_word);
            ctl_q  <= ctl_of(ld_word);
        end else begin
            if (cond_we) begin
                cond_q <= cond_nxt;
            end
            ctl_q <= (ctl_q & ~ctl_clr) | ctl_set;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (cond_q == '0) && (ctl_q == '0)); // R2

    AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && ctl_set == '0 && ctl_clr == '0) |=> $stable(ctl_q)); // R9

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && ctl_set[0] && ctl_clr[0]) |=> ctl_q[0]); // R9

    AST_COND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && (!upd_en || op == OP_NONE)) |=> $stable(cond_q)); // R11

    AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && upd_en && op[2] && op != OP_NONE) |=> (!cond_q.cf_f && !cond_q.of_f)); // R8

    AST_LOGIC_KEEPS_AF: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && upd_en && op[2]) |=> $stable(cond_q.af_f)); // R8

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (pack_word(cond_q, ctl_q) == ($past(ld_word) & 16'h0FD5))); // R10

endmodule

// File: rtl/psw_flag_unit.sv
// Module: psw_flag_unit (top)
// Status word register: derives condition flags from the current operation,
// holds control flags under explicit commands, and presents the packed word.
// Assumes operands are stable around the sampling edge.
module psw_flag_unit
    import psw_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [2:0]        op,
    input  logic              wide,
    input  logic              upd_en,
    input  logic [2:0]        ctl_set,
    input  logic [2:0]        ctl_clr,
    input  logic              ld_en,
    input  logic [15:0]       ld_word,
    output logic [15:0]       flags
);
    cond_t            cond_nxt;
    cond_t            cond_q;
    logic [CTL_N-1:0] ctl_q;

    psw_cond_eval #(.DATA_W(DATA_W)) eval_i (
        .opa      (opa),
        .opb      (opb),
        .op       (op),
        .wide     (wide),
        .cur_cf   (cond_q.cf_f),
        .cur_af   (cond_q.af_f),
        .cond_nxt (cond_nxt)
    );

    psw_state_reg state_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_en    (ld_en),
        .ld_word  (ld_word),
        .upd_en   (upd_en),
        .op       (op),
        .ctl_set  (ctl_set),
        .ctl_clr  (ctl_clr),
        .cond_nxt (cond_nxt),
        .cond_q   (cond_q),
        .ctl_q    (ctl_q)
    );

    // Present the packed word with reserved bits at zero.
    always_comb begin
        flags = pack_word(cond_q, ctl_q);
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (flags & 16'hF02A) == 16'h0000); // R1

endmodule

// File: tb/psw_flag_unit_tb_top.sv
`timescale 1ns/1ps
// Bench: directed corners plus seeded random traffic, checked against a
// reference model written with integer arithmetic.
module psw_flag_unit_tb_top;
    localparam logic [15:0] DEF_MASK = 16'h0FD5;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] opa, opb, ld_word;
    logic [2:0]  op, ctl_set, ctl_clr;
    logic        wide, upd_en, ld_en;
    logic [15:0] flags;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] exp_w = 16'h0000;
    bit done = 0;

    always #2.5 clk = ~clk;

    psw_flag_unit dut_i (
        .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .op(op), .wide(wide),
        .upd_en(upd_en), .ctl_set(ctl_set), .ctl_clr(ctl_clr),
        .ld_en(ld_en), .ld_word(ld_word), .flags(flags)
    );

    // Reference model of the next status word.
    function automatic logic [15:0] model(logic [15:0] cur);
        logic [15:0] n;
        int w, m, au, bu, cin, t, r, sa, sb, st, lo, hi;
        if (!rst_n) return 16'h0000;
        if (ld_en) return ld_word & DEF_MASK;
        n = cur;
        for (int i = 0; i < 3; i++) begin
            if (ctl_set[i]) n[8+i] = 1'b1;
            else if (ctl_clr[i]) n[8+i] = 1'b0;
        end
        if (upd_en && op != 3'd7) begin
            w   = wide ? 16 : 8;
            m   = (1 << w) - 1;
            au  = int'(opa) & m;
            bu  = int'(opb) & m;
            cin = (op == 3'd1 || op == 3'd3) ? int'(cur[0]) : 0;
            sa  = (au >= (1 << (w-1))) ? au - (1 << w) : au;
            sb  = (bu >= (1 << (w-1))) ? bu - (1 << w) : bu;
            hi  = (1 << (w-1)) - 1;
            lo  = -(1 << (w-1));
            if (op <= 3'd1) begin
                t = au + bu + cin;
                r = t & m;
                n[0]  = (t > m);
                n[4]  = (((au & 15) + (bu & 15) + cin) > 15);
                st    = sa + sb + cin;
                n[11] = (st > hi) || (st < lo);
            end else if (op <= 3'd3) begin
                t = au - bu - cin;
                r = t & m;
                n[0]  = (t < 0);
                n[4]  = ((au & 15) < ((bu & 15) + cin));
                st    = sa - sb - cin;
                n[11] = (st > hi) || (st < lo);
            end else begin
                if (op == 3'd4) r = au & bu;
                else if (op == 3'd5) r = au | bu;
                else r = au ^ bu;
                n[0]  = 1'b0;
                n[11] = 1'b0;
            end
            n[6] = (r == 0);
            n[7] = ((r >> (w-1)) & 1) != 0;
            n[2] = ($countones(r & 255) % 2) == 0;
        end
        return n;
    endfunction

    function automatic string tag_of(logic [15:0] d);
        if ((d & ~DEF_MASK) != 0) return "R1";
        if (d[0]) return "R5";
        if (d[2]) return "R4";
        if (d[4]) return "R6";
        if (d[6] || d[7]) return "R3";
        if (d[11]) return "R7";
        return "R9";
    endfunction

    task automatic idle();
        upd_en = 0; ld_en = 0; ctl_set = 0; ctl_clr = 0; op = 3'd7;
        opa = 0; opb = 0; wide = 0; ld_word = 0; rst_n = 1;
    endtask

    // One clock with the current inputs, then compare against the model.
    task automatic step(string tag);
        logic [15:0] e;
        string t;
        e = model(exp_w);
        @(posedge clk);
        #1;
        exp_w = e;
        n_chk++;
        if (flags !== e) begin
            n_bad++;
            t = (tag == "") ? tag_of(flags ^ e) : tag;
            $display("FAIL %s: flags=%h expected=%h", t, flags, e);
        end
        if ((flags & ~DEF_MASK) !== 16'h0) begin
            n_bad++;
            $display("FAIL R1: reserved bits set, flags=%h expected=%h", flags, flags & DEF_MASK);
        end
        @(negedge clk);
        idle();
    endtask

    task automatic arith(logic [2:0] o, logic wd, logic [15:0] a, logic [15:0] b, string tag);
        op = o; wide = wd; opa = a; opb = b; upd_en = 1;
        step(tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, count=%0d expected=0", 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        logic [31:0] rv;
        seed = 32'h5A17;
        rv = $urandom(seed);
        idle();
        rst_n = 0;
        @(negedge clk);
        rst_n = 0;
        step("R2");                                             // R2 reset value 0
        // R10 load all ones: only defined bits land
        ld_en = 1; ld_word = 16'hFFFF; step("R10");
        // R10 load wins over simultaneous requests
        ld_en = 1; ld_word = 16'h0001; ctl_set = 3'b111; upd_en = 1; op = 3'd0;
        opa = 16'hFFFF; opb = 16'h0001; wide = 1; step("R10");
        // R2 reset mid-run
        rst_n = 0; step("R2");
        // R7 byte 0x7F + 1: overflow, sign, aux, odd parity
        arith(3'd0, 0, 16'h007F, 16'h0001, "R7");
        // R3 byte 0xFF + 1 with junk upper bits: zero over low byte, carry
        arith(3'd0, 0, 16'h12FF, 16'h3401, "R3");
        // R5 adc chains the carry: 0x00FF + 0 + 1 at byte width
        arith(3'd1, 0, 16'h00FF, 16'h0000, "R5");
        // R5 word borrow through zero: 0 - 1
        arith(3'd2, 1, 16'h0000, 16'h0001, "R5");
        // R5 sbb uses borrow-in (carry now 1): 5 - 5 - 1
        arith(3'd3, 1, 16'h0005, 16'h0005, "R5");
        // R7 word 0x8000 + 0x8000
        arith(3'd0, 1, 16'h8000, 16'h8000, "R7");
        // R6 aux carry from nibble: 0x0008 + 0x0008
        arith(3'd0, 1, 16'h0008, 16'h0008, "R6");
        // R8 logical after aux set: AF kept, CF/OF cleared
        arith(3'd4, 1, 16'hF0F0, 16'h0FF0, "R8");
        // R4 parity from low byte only at word width
        arith(3'd6, 1, 16'hFF03, 16'h0000, "R4");
        // R3 sign from bit 15 at word width
        arith(3'd5, 1, 16'h8000, 16'h0001, "R3");
        // R11 enable low: no change
        op = 3'd0; wide = 1; opa = 16'hFFFF; opb = 16'hFFFF; upd_en = 0; step("R11");
        // R11 op code 7: no change
        op = 3'd7; opa = 16'hFFFF; opb = 16'h0001; upd_en = 1; step("R11");
        // R9 set and clear: set wins; arithmetic leaves control alone
        ctl_set = 3'b101; ctl_clr = 3'b111; step("R9");
        arith(3'd2, 0, 16'h0010, 16'h0020, "R9");
        ctl_clr = 3'b001; step("R9");
        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            rst_n   = ($urandom % 97) != 0;
            opa     = 16'($urandom);
            opb     = ($urandom % 8 == 0) ? opa : 16'($urandom);
            op      = 3'($urandom);
            wide    = 1'($urandom);
            upd_en  = ($urandom % 5) != 0;
            ctl_set = 3'($urandom) & 3'($urandom);
            ctl_clr = 3'($urandom) & 3'($urandom);
            ld_en   = ($urandom % 16) == 0;
            ld_word = 16'($urandom);
            step("");
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule